// File: doc/BRIEF.md
# Translation Unit Control and Status Registers

This block is the software-visible control point of a device-side address-translation unit. It stores the base address of the translation table and turns writes to a command register into the mode changes of the translation datapath: paging on and off, stall request and release, fault acknowledge, whole-cache flush and a force reset that returns every register to zero. It reports what the datapath is doing through a status word. That word carries paging, fault, stall, idle, replay-empty and fault-direction bits, plus a bit that is set while the stall is not active.

Toward the datapath the block drives the paging enable, the stall request, the table base, a flush pulse and a single-line invalidate pulse with its address. From the datapath it takes fault events with address and direction, bus-error events, an idle flag and a replay-empty flag. Two interrupt sources, page fault and bus error, are latched in a raw register, gated by a mask and combined into one interrupt line. Software acknowledges them by writing ones to a clear register.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset every stored register reads zero, paging_en, stall_req, flush_all, inval_valid, clk_gate_en and irq are low, and the status word at offset 0x04 reads 0x8000_0000 with xlat_idle in bit 3 and replay_empty in bit 4.
- R2: The table base at offset 0x00 keeps only bits 31:12 of a write; writing 0xCAFEBABE reads back as 0xCAFEB000 and appears on table_base in the cycle after the write.
- R3: A write of 0 to the command register at offset 0x08 sets paging_en and status bit 0 in the next cycle. A write of 1 clears both and also drops the stall request.
- R4: Command 2 raises stall_req in the next cycle only if paging is already enabled, and is otherwise ignored; command 3 lowers stall_req.
- R5: Status bit 2 (stall active) is high when stall_req is high and xlat_idle is high; status bit 31 is always its inverse.
- R6: A fault_evt cycle sets status bit 1, stores fault_addr at offset 0x0C and fault_is_write in status bit 5. Command 5 clears bit 1, but a fault_evt in the same cycle wins.
- R7: Raw interrupt bits at offset 0x14 are bit 0 page fault and bit 1 bus error. Each is set by its event and cleared by writing a one in that position to offset 0x18, and an event in the same cycle as the clear wins.
- R8: Offset 0x1C holds a 2-bit mask. Offset 0x20 reads raw AND mask, and irq is high whenever that result is non-zero.
- R9: Command 4 gives a one-cycle flush_all pulse in the next cycle. A write to offset 0x10 gives a one-cycle inval_valid pulse in the next cycle, with inval_addr equal to the written data.
- R10: Command 6 clears table base, paging, stall, fault state and address, raw interrupts, mask, invalidate address and gating in the next cycle, overriding any event in the same cycle.
- R11: Offsets not listed read zero and ignore writes. Offsets 0x08, 0x10 and 0x18 read zero, writes to 0x14 and 0x20 have no effect, and command values above 6 do nothing.
- R12: Bit 0 of offset 0x24 is a read/write gating enable driven on clk_gate_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | OFF_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| paging_en | output | 1 | Translation enabled |
| stall_req | output | 1 | Request to stall translation |
| table_base | output | DATA_W | Translation table base, low PAGE_SHIFT bits zero |
| flush_all | output | 1 | Pulse: flush the whole translation cache |
| inval_valid | output | 1 | Pulse: invalidate one cached line |
| inval_addr | output | DATA_W | Address of the line to invalidate |
| clk_gate_en | output | 1 | Automatic clock gating enable |
| xlat_idle | input | 1 | No translation in flight |
| replay_empty | input | 1 | Datapath replay buffer empty |
| fault_evt | input | 1 | Page fault event |
| fault_is_write | input | 1 | Faulting access was a write |
| fault_addr | input | DATA_W | Faulting address |
| buserr_evt | input | 1 | Bus read error event |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situations to reach are the same-cycle collisions: a fault event landing in the cycle of a fault-acknowledge command or an interrupt clear, and a force reset landing on top of events. Directed sequences set these up deliberately. A long random phase follows, mixing command writes, including out-of-range codes and force resets, with events and a toggling idle flag. A behavioural model in the bench predicts every output and the read data of the current offset on every cycle.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
   // byte offsets of the register window
   localparam logic [7:0] OFF_BASE   = 8'h00;
   localparam logic [7:0] OFF_STAT   = 8'h04;
   localparam logic [7:0] OFF_CMD    = 8'h08;
   localparam logic [7:0] OFF_FADDR  = 8'h0C;
   localparam logic [7:0] OFF_INVAL  = 8'h10;
   localparam logic [7:0] OFF_RAW    = 8'h14;
   localparam logic [7:0] OFF_CLR    = 8'h18;
   localparam logic [7:0] OFF_MASK   = 8'h1C;
   localparam logic [7:0] OFF_PEND   = 8'h20;
   localparam logic [7:0] OFF_GATE   = 8'h24;

   typedef enum logic [2:0] {
      CMD_PG_ON     = 3'd0,
      CMD_PG_OFF    = 3'd1,
      CMD_STALL_ON  = 3'd2,
      CMD_STALL_OFF = 3'd3,
      CMD_FLUSH     = 3'd4,
      CMD_FAULT_ACK = 3'd5,
      CMD_WIPE      = 3'd6,
      CMD_NONE      = 3'd7
   } xcmd_e;
endpackage

// File: rtl/xlat_mode_ctrl.sv
module xlat_mode_ctrl
   import xlat_regs_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_vld,
   input  xcmd_e         cmd,
   input  logic          xlat_idle,
   input  logic          fault_evt,
   input  logic          fault_is_write,
   input  logic [AW-1:0] fault_addr,
   output logic          paging_q,
   output logic          stall_req_q,
   output logic          stall_act,
   output logic          fault_act_q,
   output logic          fault_wr_q,
   output logic [AW-1:0] fault_addr_q,
   output logic          flush_q
);
   logic wipe;
   assign wipe = cmd_vld && (cmd == CMD_WIPE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paging_q     <= 1'b0;
         stall_req_q  <= 1'b0;
         fault_act_q  <= 1'b0;
         fault_wr_q   <= 1'b0;
         fault_addr_q <= '0;
         flush_q      <= 1'b0;
      end else if (wipe) begin
         paging_q     <= 1'b0;
         stall_req_q  <= 1'b0;
         fault_act_q  <= 1'b0;
         fault_wr_q   <= 1'b0;
         fault_addr_q <= '0;
         flush_q      <= 1'b0;
      end else begin
         flush_q <= cmd_vld && (cmd == CMD_FLUSH);
         if (cmd_vld) begin
            case (cmd)
               CMD_PG_ON:     paging_q <= 1'b1;
               CMD_PG_OFF:    begin paging_q <= 1'b0; stall_req_q <= 1'b0; end
               CMD_STALL_ON:  if (paging_q) stall_req_q <= 1'b1;
               CMD_STALL_OFF: stall_req_q <= 1'b0;
               default:       ;
            endcase
         end
         if (fault_evt) begin
            fault_act_q  <= 1'b1;
            fault_wr_q   <= fault_is_write;
            fault_addr_q <= fault_addr;
         end else if (cmd_vld && (cmd == CMD_FAULT_ACK)) begin
            fault_act_q <= 1'b0;
         end
      end
   end

   // stall is only reported once the datapath has drained
   assign stall_act = stall_req_q & xlat_idle;
endmodule

// File: rtl/xlat_irq_unit.sv
module xlat_irq_unit #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wipe,
   input  logic [NSRC-1:0] src,
   input  logic            clr_wr,
   input  logic [NSRC-1:0] clr_bits,
   input  logic            mask_wr,
   input  logic [NSRC-1:0] mask_bits,
   output logic [NSRC-1:0] raw_q,
   output logic [NSRC-1:0] mask_q,
   output logic [NSRC-1:0] pend,
   output logic            irq
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       raw_q[i] <= 1'b0;
         else if (wipe)                    raw_q[i] <= 1'b0;
         else if (src[i])                  raw_q[i] <= 1'b1;
         else if (clr_wr && clr_bits[i])   raw_q[i] <= 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mask_q[i] <= 1'b0;
         else if (wipe)    mask_q[i] <= 1'b0;
         else if (mask_wr) mask_q[i] <= mask_bits[i];
      end
   end

   assign pend = raw_q & mask_q;
   assign irq  = |pend;
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
   import xlat_regs_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 8,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [OFF_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              paging_en,
   output logic              stall_req,
   output logic [DATA_W-1:0] table_base,
   output logic              flush_all,
   output logic              inval_valid,
   output logic [DATA_W-1:0] inval_addr,
   output logic              clk_gate_en,
   input  logic              xlat_idle,
   input  logic              replay_empty,
   input  logic              fault_evt,
   input  logic              fault_is_write,
   input  logic [DATA_W-1:0] fault_addr,
   input  logic              buserr_evt,
   output logic              irq
);
   localparam int NSRC   = 2;
   localparam int BASE_W = DATA_W - PAGE_SHIFT;

   if (DATA_W != 32) begin : g_bad_dw
      $error("xlat_ctrl_regs: DATA_W must be 32");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W) begin : g_bad_ps
      $error("xlat_ctrl_regs: PAGE_SHIFT out of range");
   end
   if (OFF_W < 6) begin : g_bad_ow
      $error("xlat_ctrl_regs: OFF_W too small for the register window");
   end

   // write decode
   logic  hit_base, hit_cmd, hit_inval, hit_clr, hit_mask, hit_gate;
   logic  cmd_vld, wipe;
   xcmd_e cmd;
   assign hit_base  = reg_we && (reg_addr == OFF_W'(OFF_BASE));
   assign hit_cmd   = reg_we && (reg_addr == OFF_W'(OFF_CMD));
   assign hit_inval = reg_we && (reg_addr == OFF_W'(OFF_INVAL));
   assign hit_clr   = reg_we && (reg_addr == OFF_W'(OFF_CLR));
   assign hit_mask  = reg_we && (reg_addr == OFF_W'(OFF_MASK));
   assign hit_gate  = reg_we && (reg_addr == OFF_W'(OFF_GATE));
   assign cmd       = xcmd_e'(reg_wdata[2:0]);
   assign cmd_vld   = hit_cmd && (reg_wdata[DATA_W-1:3] == '0);
   assign wipe      = cmd_vld && (cmd == CMD_WIPE);

   // mode and fault state
   logic              stall_act, fault_act_q, fault_wr_q;
   logic [DATA_W-1:0] fault_addr_q;

   xlat_mode_ctrl #(.AW(DATA_W)) u_mode (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_vld        (cmd_vld),
      .cmd            (cmd),
      .xlat_idle      (xlat_idle),
      .fault_evt      (fault_evt),
      .fault_is_write (fault_is_write),
      .fault_addr     (fault_addr),
      .paging_q       (paging_en),
      .stall_req_q    (stall_req),
      .stall_act      (stall_act),
      .fault_act_q    (fault_act_q),
      .fault_wr_q     (fault_wr_q),
      .fault_addr_q   (fault_addr_q),
      .flush_q        (flush_all)
   );

   // interrupt sources: bit 0 page fault, bit 1 bus error
   logic [NSRC-1:0] irq_raw, irq_mask, irq_pend;

   xlat_irq_unit #(.NSRC(NSRC)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wipe      (wipe),
      .src       ({buserr_evt, fault_evt}),
      .clr_wr    (hit_clr),
      .clr_bits  (reg_wdata[NSRC-1:0]),
      .mask_wr   (hit_mask),
      .mask_bits (reg_wdata[NSRC-1:0]),
      .raw_q     (irq_raw),
      .mask_q    (irq_mask),
      .pend      (irq_pend),
      .irq       (irq)
   );

   // plain storage: table base, invalidate request, gating
   logic [BASE_W-1:0] base_hi_q;
   logic              gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi_q   <= '0;
         gate_q      <= 1'b0;
         inval_valid <= 1'b0;
         inval_addr  <= '0;
      end else if (wipe) begin
         base_hi_q   <= '0;
         gate_q      <= 1'b0;
         inval_valid <= 1'b0;
         inval_addr  <= '0;
      end else begin
         inval_valid <= hit_inval;
         if (hit_base)  base_hi_q  <= reg_wdata[DATA_W-1:PAGE_SHIFT];
         if (hit_gate)  gate_q     <= reg_wdata[0];
         if (hit_inval) inval_addr <= reg_wdata;
      end
   end

   assign table_base  = {base_hi_q, {PAGE_SHIFT{1'b0}}};
   assign clk_gate_en = gate_q;

   // status word
   logic [DATA_W-1:0] status;
   always_comb begin
      status           = '0;
      status[0]        = paging_en;
      status[1]        = fault_act_q;
      status[2]        = stall_act;
      status[3]        = xlat_idle;
      status[4]        = replay_empty;
      status[5]        = fault_wr_q;
      status[DATA_W-1] = ~stall_act;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_W'(OFF_BASE):  reg_rdata = table_base;
         OFF_W'(OFF_STAT):  reg_rdata = status;
         OFF_W'(OFF_FADDR): reg_rdata = fault_addr_q;
         OFF_W'(OFF_RAW):   reg_rdata = {{(DATA_W-NSRC){1'b0}}, irq_raw};
         OFF_W'(OFF_MASK):  reg_rdata = {{(DATA_W-NSRC){1'b0}}, irq_mask};
         OFF_W'(OFF_PEND):  reg_rdata = {{(DATA_W-NSRC){1'b0}}, irq_pend};
         OFF_W'(OFF_GATE):  reg_rdata = {{(DATA_W-1){1'b0}}, gate_q};
         default:           reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/xlat_ctrl_regs_chk.sv
module xlat_ctrl_regs_chk
   import xlat_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OFF_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [OFF_W-1:0]  reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              paging_en,
   input logic              stall_req,
   input logic [DATA_W-1:0] table_base,
   input logic              flush_all,
   input logic              irq,
   input logic              fault_evt,
   input logic              fault_act,
   input logic [1:0]        raw
);
   logic cw;
   assign cw = reg_we && (reg_addr == OFF_W'(OFF_CMD));

   logic c_pg_on, c_stall_on, c_flush, c_ack, c_wipe;
   assign c_pg_on    = cw && (reg_wdata == DATA_W'(0));
   assign c_stall_on = cw && (reg_wdata == DATA_W'(2));
   assign c_flush    = cw && (reg_wdata == DATA_W'(4));
   assign c_ack      = cw && (reg_wdata == DATA_W'(5));
   assign c_wipe     = cw && (reg_wdata == DATA_W'(6));

   AST_PAGING_ON: assert property (@(posedge clk) disable iff (!rst_n)
      c_pg_on |=> paging_en); // R3
   AST_STALL_NEEDS_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |-> paging_en); // R4
   AST_STALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (c_stall_on && !paging_en) |=> !stall_req); // R4
   AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_evt && !c_wipe) |=> fault_act); // R6
   AST_FAULT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ack && !fault_evt) |=> !fault_act); // R6
   AST_RAW_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_evt && !c_wipe) |=> raw[0]); // R7
   AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      c_flush |=> flush_all); // R9
   AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      c_wipe |=> (table_base == '0 && !paging_en && !irq && !fault_act)); // R10
endmodule

bind xlat_ctrl_regs xlat_ctrl_regs_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .paging_en  (paging_en),
   .stall_req  (stall_req),
   .table_base (table_base),
   .flush_all  (flush_all),
   .irq        (irq),
   .fault_evt  (fault_evt),
   .fault_act  (fault_act_q),
   .raw        (irq_raw)
);

// File: tb/xlat_ctrl_regs_bench.sv
`timescale 1ns/1ps
module xlat_ctrl_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        paging_en, stall_req, flush_all, inval_valid, clk_gate_en, irq;
   logic [31:0] table_base, inval_addr;
   logic        xlat_idle = 1'b1;
   logic        replay_empty = 1'b1;
   logic        fault_evt = 1'b0;
   logic        fault_is_write = 1'b0;
   logic [31:0] fault_addr = '0;
   logic        buserr_evt = 1'b0;

   int    n_chk = 0;
   int    n_err = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   xlat_ctrl_regs u_xlat_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .paging_en(paging_en),
      .stall_req(stall_req), .table_base(table_base), .flush_all(flush_all),
      .inval_valid(inval_valid), .inval_addr(inval_addr), .clk_gate_en(clk_gate_en),
      .xlat_idle(xlat_idle), .replay_empty(replay_empty), .fault_evt(fault_evt),
      .fault_is_write(fault_is_write), .fault_addr(fault_addr),
      .buserr_evt(buserr_evt), .irq(irq));

   // behavioural reference model
   logic [31:0] m_base = '0, m_faddr = '0, m_iaddr = '0;
   logic        m_pg = 0, m_st = 0, m_flt = 0, m_fw = 0, m_gate = 0, m_flush = 0, m_inv = 0;
   logic [1:0]  m_raw = '0, m_mask = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_base = '0; m_faddr = '0; m_iaddr = '0; m_pg = 0; m_st = 0; m_flt = 0;
         m_fw = 0; m_gate = 0; m_flush = 0; m_inv = 0; m_raw = '0; m_mask = '0;
      end else if (reg_we && reg_addr == 8'h08 && reg_wdata == 32'd6) begin
         m_base = '0; m_faddr = '0; m_iaddr = '0; m_pg = 0; m_st = 0; m_flt = 0;
         m_fw = 0; m_gate = 0; m_flush = 0; m_inv = 0; m_raw = '0; m_mask = '0;
      end else begin
         m_flush = reg_we && reg_addr == 8'h08 && reg_wdata == 32'd4;
         m_inv   = reg_we && reg_addr == 8'h10;
         if (m_inv) m_iaddr = reg_wdata;
         if (reg_we && reg_addr == 8'h00) m_base = reg_wdata & 32'hFFFF_F000;
         if (reg_we && reg_addr == 8'h24) m_gate = reg_wdata[0];
         if (reg_we && reg_addr == 8'h1C) m_mask = reg_wdata[1:0];
         if (reg_we && reg_addr == 8'h08) begin
            if (reg_wdata == 0) m_pg = 1;
            else if (reg_wdata == 1) begin m_pg = 0; m_st = 0; end
            else if (reg_wdata == 2) begin if (m_pg) m_st = 1; end
            else if (reg_wdata == 3) m_st = 0;
         end
         if (fault_evt) begin m_flt = 1; m_fw = fault_is_write; m_faddr = fault_addr; end
         else if (reg_we && reg_addr == 8'h08 && reg_wdata == 32'd5) m_flt = 0;
         if (reg_we && reg_addr == 8'h18) m_raw = m_raw & ~reg_wdata[1:0];
         m_raw = m_raw | {buserr_evt, fault_evt};
      end
   end

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      logic sa;
      sa = m_st & xlat_idle;
      case (a)
         8'h00: return m_base;
         8'h04: return {~sa, 25'd0, m_fw, replay_empty, xlat_idle, sa, m_flt, m_pg};
         8'h0C: return m_faddr;
         8'h14: return {30'd0, m_raw};
         8'h1C: return {30'd0, m_mask};
         8'h20: return {30'd0, m_raw & m_mask};
         8'h24: return {31'd0, m_gate};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cmp_all();
      chk("R2 table_base", table_base, m_base);
      chk("R3 paging_en", {31'd0, paging_en}, {31'd0, m_pg});
      chk("R4 stall_req", {31'd0, stall_req}, {31'd0, m_st});
      chk("R8 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
      chk("R9 flush_all", {31'd0, flush_all}, {31'd0, m_flush});
      chk("R9 inval_valid", {31'd0, inval_valid}, {31'd0, m_inv});
      chk("R9 inval_addr", inval_addr, m_iaddr);
      chk("R12 clk_gate_en", {31'd0, clk_gate_en}, {31'd0, m_gate});
      chk($sformatf("%s rdata@%h", phase, reg_addr), reg_rdata, exp_rd(reg_addr));
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      cmp_all();
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_we = 0; fault_evt = 0; buserr_evt = 0;
   endtask

   task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
      reg_we = 0; reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      // R1 reset state
      rd_chk("R1 status after reset", 8'h04, 32'h8000_0018);
      rd_chk("R1 base after reset", 8'h00, 32'h0);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      // R2 table base
      phase = "R2";
      wr(8'h00, 32'hCAFE_BABE);
      rd_chk("R2 base readback", 8'h00, 32'hCAFE_B000);
      chk("R2 base output", table_base, 32'hCAFE_B000);
      // R4 stall refused without paging
      phase = "R4";
      wr(8'h08, 32'd2);
      chk("R4 stall refused", {31'd0, stall_req}, 32'd0);
      // R3 paging on
      phase = "R3";
      wr(8'h08, 32'd0);
      chk("R3 paging on", {31'd0, paging_en}, 32'd1);
      // R5 stall active needs idle
      phase = "R5";
      xlat_idle = 0;
      wr(8'h08, 32'd2);
      rd_chk("R5 stall pending busy", 8'h04, 32'h8000_0011);
      xlat_idle = 1;
      rd_chk("R5 stall active idle", 8'h04, 32'h0000_001D);
      cyc();
      wr(8'h08, 32'd3);
      chk("R4 stall released", {31'd0, stall_req}, 32'd0);
      wr(8'h08, 32'd2);
      wr(8'h08, 32'd1);
      chk("R3 paging off drops stall", {30'd0, paging_en, stall_req}, 32'd0);
      // R6 fault capture and acknowledge
      phase = "R6";
      fault_evt = 1; fault_is_write = 1; fault_addr = 32'h1234_5678;
      cyc();
      fault_evt = 0;
      rd_chk("R6 fault addr", 8'h0C, 32'h1234_5678);
      rd_chk("R6 fault status", 8'h04, 32'h8000_003A);
      wr(8'h08, 32'd5);
      rd_chk("R6 fault cleared", 8'h04, 32'h8000_0038);
      fault_evt = 1; fault_is_write = 0; fault_addr = 32'h0000_4000;
      wr(8'h08, 32'd5);
      rd_chk("R6 event beats ack", 8'h04, 32'h8000_001A);
      // R7/R8 interrupts
      phase = "R7";
      rd_chk("R7 raw fault", 8'h14, 32'h1);
      chk("R8 masked off", {31'd0, irq}, 32'd0);
      wr(8'h1C, 32'h3);
      chk("R8 irq on", {31'd0, irq}, 32'd1);
      buserr_evt = 1;
      wr(8'h18, 32'h3);
      rd_chk("R7 clear vs bus error", 8'h14, 32'h2);
      rd_chk("R8 pending", 8'h20, 32'h2);
      wr(8'h18, 32'h2);
      chk("R8 irq off", {31'd0, irq}, 32'd0);
      // R9 flush and invalidate
      phase = "R9";
      wr(8'h08, 32'd4);
      chk("R9 flush pulse", {31'd0, flush_all}, 32'd1);
      cyc();
      chk("R9 flush ends", {31'd0, flush_all}, 32'd0);
      wr(8'h10, 32'h0040_3000);
      chk("R9 inval addr", inval_addr, 32'h0040_3000);
      // R12 gating
      phase = "R12";
      wr(8'h24, 32'h1);
      chk("R12 gate on", {31'd0, clk_gate_en}, 32'd1);
      // R11 ignored accesses
      phase = "R11";
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h14, 32'h3);
      wr(8'h20, 32'h3);
      wr(8'h08, 32'd7);
      rd_chk("R11 unmapped read", 8'h28, 32'h0);
      rd_chk("R11 raw write ignored", 8'h14, 32'h0);
      rd_chk("R11 cmd reads zero", 8'h08, 32'h0);
      rd_chk("R11 gate unchanged", 8'h24, 32'h1);
      // R10 force reset
      phase = "R10";
      wr(8'h08, 32'd0);
      buserr_evt = 1; fault_evt = 1;
      wr(8'h08, 32'd6);
      rd_chk("R10 base zero", 8'h00, 32'h0);
      rd_chk("R10 raw zero", 8'h14, 32'h0);
      rd_chk("R10 mask zero", 8'h1C, 32'h0);
      rd_chk("R10 status", 8'h04, 32'h8000_0018);
      // random traffic against the model
      phase = "RND";
      for (int i = 0; i < 600; i++) begin
         reg_we     = ($urandom % 2) == 0;
         reg_addr   = 8'(($urandom % 12) * 4);
         reg_wdata  = (reg_addr == 8'h08) ? ($urandom % 8) : $urandom;
         if (reg_addr == 8'h08 && reg_wdata == 6 && ($urandom % 4) != 0) reg_wdata = 0;
         fault_evt  = ($urandom % 5) == 0;
         fault_is_write = $urandom % 2;
         fault_addr = $urandom;
         buserr_evt = ($urandom % 6) == 0;
         xlat_idle  = ($urandom % 4) != 0;
         replay_empty = $urandom % 2;
         cyc();
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule